// File: doc/BRIEF.md
# Readout Mode Lane Multiplexer

This block chooses the word that each lane of a sensor video link sends on every clock. There are several data lanes and one sync lane. A pair of control bits selects one of three modes. In link-training mode, every lane repeats two idle words in alternation, so a receiver can find its word alignment and remove skew between lanes. In test-image mode, the frame and line framing and the timing of data slots are the same as in live readout, but every data slot carries one fixed programmable word. In normal readout, each data lane carries the ADC word for that lane.

The sync lane sends one-clock keywords that mark where a frame or a line begins and ends. These keywords come from rising and falling edges of the frame-valid and line-valid inputs. In the cycles between keywords and between data slots, the lanes send the alternating idle words, so the stream always has a fixed shape. The block takes a new mode only while no frame is active, so a mode change never splits a frame. Serialization happens downstream of this block.

Top module: `readout_lane_mux`

## Requirements
- R1: While reset is high, every lane output and the sync output read zero. In the first clock after reset is released, any lane that shows an idle word shows the first idle word (idle_a_i).
- R2: The mode is decoded from two bits. cfg_bypass=0 selects normal readout whatever cfg_train_en holds. cfg_bypass=1 with cfg_train_en=1 selects training. cfg_bypass=1 with cfg_train_en=0 selects test image.
- R3: In training mode, every data lane and the sync lane send the same idle word on every clock. The frame, line and data-valid inputs have no effect.
- R4: In test-image mode, during every data slot, each data lane sends test_word_i in place of its ADC word. A data slot is a cycle in which frame_valid_i, line_valid_i and adc_valid_i are all high.
- R5: In normal readout, during a data slot, data lane k sends bits [k*WORD_W +: WORD_W] of adc_data_i.
- R6: In normal and test-image modes, outside data slots, the data lanes send the idle word, and the sync lane sends it too when it has no keyword to send.
- R7: In normal and test-image modes, the sync lane sends a keyword for one clock on each input edge:
  - frame-start on a rising edge of frame_valid_i
  - frame-end on a falling edge of frame_valid_i
  - line-start on a rising edge of line_valid_i
  - line-end on a falling edge of line_valid_i

  When edges fall in the same cycle, the priority is frame-start, then frame-end, then line-start, then line-end. In all other cycles the sync lane sends the idle word.
- R8: The control bits are taken only in cycles where frame_valid_i is low. While a frame is active, the mode in use stays fixed.
- R9: Each output is registered. It reflects the inputs of the clock before. The idle sequence alternates idle_a_i, idle_b_i on every clock in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_train_en | input | 1 | Selects training when the bypass bit is set |
| cfg_bypass | input | 1 | Moves the block off live ADC data |
| idle_a_i | input | WORD_W | First idle word |
| idle_b_i | input | WORD_W | Second idle word |
| test_word_i | input | WORD_W | Fixed word for test-image data slots |
| kw_frame_start_i | input | WORD_W | Frame-start keyword |
| kw_line_start_i | input | WORD_W | Line-start keyword |
| kw_line_end_i | input | WORD_W | Line-end keyword |
| kw_frame_end_i | input | WORD_W | Frame-end keyword |
| frame_valid_i | input | 1 | High for the whole of a frame |
| line_valid_i | input | 1 | High for the whole of a line |
| adc_valid_i | input | 1 | ADC words present this cycle |
| adc_data_i | input | LANES*WORD_W | One ADC word per data lane |
| lane_data_o | output | LANES*WORD_W | One output word per data lane |
| sync_word_o | output | WORD_W | Sync lane output word |

## Verification
The bench goes after frames whose first line starts in the same cycle as the frame. A design with the wrong priority would send line-start there in place of frame-start, or would send line-end where frame-end belongs when both signals fall together. It also changes the control bits in the middle of a frame. A design that takes the new bits at once would switch lanes to test words or idle words halfway through the frame. One-cycle lines and data-valid gaps inside lines check that idle fill keeps its phase across slots. Without that, a design would send the wrong idle word, or leave an ADC word on the lane after its slot ends.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TEST   = 2'd1,
    MODE_TRAIN  = 2'd2
  } rlm_mode_e;

  typedef enum logic [2:0] {
    KW_NONE = 3'd0,
    KW_FS   = 3'd1,
    KW_FE   = 3'd2,
    KW_LS   = 3'd3,
    KW_LE   = 3'd4
  } rlm_kw_e;

  function automatic rlm_mode_e rlm_decode(input logic train_en, input logic bypass);
    if (!bypass)      return MODE_NORMAL;
    else if (train_en) return MODE_TRAIN;
    else              return MODE_TEST;
  endfunction

endpackage

// File: rtl/rlm_mode_ctrl.sv
module rlm_mode_ctrl
  import rlm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_train_en,
  input  logic      cfg_bypass,
  input  logic      frame_valid,
  output rlm_mode_e mode_o
);

  rlm_mode_e mode_q;

  // A new mode is taken only between frames.
  always_ff @(posedge clk) begin
    if (rst)               mode_q <= MODE_NORMAL;
    else if (!frame_valid) mode_q <= rlm_decode(cfg_train_en, cfg_bypass);
  end

  assign mode_o = mode_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> $stable(mode_q)); // R8

endmodule

// File: rtl/rlm_frame_track.sv
module rlm_frame_track
  import rlm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    frame_valid,
  input  logic    line_valid,
  input  logic    adc_valid,
  output rlm_kw_e kw_sel_o,
  output logic    slot_o,
  output logic    phase_o
);

  logic fv_prev_q, lv_prev_q, phase_q;
  logic fs_hit, fe_hit, ls_hit, le_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_prev_q <= 1'b0;
      lv_prev_q <= 1'b0;
      phase_q   <= 1'b0;
    end else begin
      fv_prev_q <= frame_valid;
      lv_prev_q <= line_valid;
      phase_q   <= ~phase_q;
    end
  end

  assign fs_hit = frame_valid  & ~fv_prev_q;
  assign fe_hit = ~frame_valid & fv_prev_q;
  assign ls_hit = line_valid   & ~lv_prev_q;
  assign le_hit = ~line_valid  & lv_prev_q;

  // Fixed priority: frame-start, frame-end, line-start, line-end.
  always_comb begin
    if (fs_hit)      kw_sel_o = KW_FS;
    else if (fe_hit) kw_sel_o = KW_FE;
    else if (ls_hit) kw_sel_o = KW_LS;
    else if (le_hit) kw_sel_o = KW_LE;
    else             kw_sel_o = KW_NONE;
  end

  assign slot_o  = frame_valid & line_valid & adc_valid;
  assign phase_o = phase_q;

endmodule

// File: rtl/rlm_lane_sel.sv
module rlm_lane_sel
  import rlm_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rlm_mode_e         mode_i,
  input  logic              slot_i,
  input  logic [WORD_W-1:0] idle_word_i,
  input  logic [WORD_W-1:0] test_word_i,
  input  logic [WORD_W-1:0] adc_word_i,
  output logic [WORD_W-1:0] lane_o
);

  logic [WORD_W-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
    end else begin
      unique case (mode_i)
        MODE_TRAIN: lane_q <= idle_word_i;
        MODE_TEST:  lane_q <= slot_i ? test_word_i : idle_word_i;
        default:    lane_q <= slot_i ? adc_word_i  : idle_word_i;
      endcase
    end
  end

  assign lane_o = lane_q;

  AST_TEST_SLOT: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_TEST && slot_i) |=> (lane_o == $past(test_word_i))); // R4

  AST_NORMAL_SLOT: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_NORMAL && slot_i) |=> (lane_o == $past(adc_word_i))); // R5

endmodule

// File: rtl/rlm_sync_sel.sv
module rlm_sync_sel
  import rlm_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  rlm_mode_e         mode_i,
  input  rlm_kw_e           kw_sel_i,
  input  logic [WORD_W-1:0] idle_word_i,
  input  logic [WORD_W-1:0] kw_fs_i,
  input  logic [WORD_W-1:0] kw_ls_i,
  input  logic [WORD_W-1:0] kw_le_i,
  input  logic [WORD_W-1:0] kw_fe_i,
  output logic [WORD_W-1:0] sync_o
);

  logic [WORD_W-1:0] sync_q;
  logic [WORD_W-1:0] kw_word;

  always_comb begin
    unique case (kw_sel_i)
      KW_FS:   kw_word = kw_fs_i;
      KW_FE:   kw_word = kw_fe_i;
      KW_LS:   kw_word = kw_ls_i;
      KW_LE:   kw_word = kw_le_i;
      default: kw_word = idle_word_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                      sync_q <= '0;
    else if (mode_i == MODE_TRAIN) sync_q <= idle_word_i;
    else                          sync_q <= kw_word;
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/readout_lane_mux.sv
module readout_lane_mux
  import rlm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_train_en,
  input  logic                    cfg_bypass,
  input  logic [WORD_W-1:0]       idle_a_i,
  input  logic [WORD_W-1:0]       idle_b_i,
  input  logic [WORD_W-1:0]       test_word_i,
  input  logic [WORD_W-1:0]       kw_frame_start_i,
  input  logic [WORD_W-1:0]       kw_line_start_i,
  input  logic [WORD_W-1:0]       kw_line_end_i,
  input  logic [WORD_W-1:0]       kw_frame_end_i,
  input  logic                    frame_valid_i,
  input  logic                    line_valid_i,
  input  logic                    adc_valid_i,
  input  logic [LANES*WORD_W-1:0] adc_data_i,
  output logic [LANES*WORD_W-1:0] lane_data_o,
  output logic [WORD_W-1:0]       sync_word_o
);

  localparam int BUS_W = LANES * WORD_W;

  rlm_mode_e         mode_w;
  rlm_kw_e           kw_sel_w;
  logic              slot_w;
  logic              phase_w;
  logic [WORD_W-1:0] idle_word_w;

  rlm_mode_ctrl u_mode (
    .clk          (clk),
    .rst          (rst),
    .cfg_train_en (cfg_train_en),
    .cfg_bypass   (cfg_bypass),
    .frame_valid  (frame_valid_i),
    .mode_o       (mode_w)
  );

  rlm_frame_track u_track (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid_i),
    .line_valid  (line_valid_i),
    .adc_valid   (adc_valid_i),
    .kw_sel_o    (kw_sel_w),
    .slot_o      (slot_w),
    .phase_o     (phase_w)
  );

  assign idle_word_w = phase_w ? idle_b_i : idle_a_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rlm_lane_sel #(.WORD_W(WORD_W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .mode_i      (mode_w),
      .slot_i      (slot_w),
      .idle_word_i (idle_word_w),
      .test_word_i (test_word_i),
      .adc_word_i  (adc_data_i[g*WORD_W +: WORD_W]),
      .lane_o      (lane_data_o[g*WORD_W +: WORD_W])
    );
  end

  rlm_sync_sel #(.WORD_W(WORD_W)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_w),
    .kw_sel_i    (kw_sel_w),
    .idle_word_i (idle_word_w),
    .kw_fs_i     (kw_frame_start_i),
    .kw_ls_i     (kw_line_start_i),
    .kw_le_i     (kw_line_end_i),
    .kw_fe_i     (kw_frame_end_i),
    .sync_o      (sync_word_o)
  );

  AST_TRAIN_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (mode_w == MODE_TRAIN) |=> (sync_word_o == lane_data_o[WORD_W-1:0])); // R3

  AST_FS_KEY: assert property (@(posedge clk) disable iff (rst)
    ($rose(frame_valid_i) && mode_w != MODE_TRAIN) |=> (sync_word_o == $past(kw_frame_start_i))); // R7

  AST_GAP_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode_w != MODE_TRAIN && !slot_w && kw_sel_w == KW_NONE)
      |=> (sync_word_o == lane_data_o[BUS_W-1 -: WORD_W])); // R6

endmodule

// File: tb/readout_lane_mux_test.sv
module readout_lane_mux_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int WORD_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_train_en = 1'b0, cfg_bypass = 1'b0;
  logic [WORD_W-1:0] idle_a, idle_b, test_word, kw_fs, kw_ls, kw_le, kw_fe;
  logic frame_valid = 1'b0, line_valid = 1'b0, adc_valid = 1'b0;
  logic [LANES*WORD_W-1:0] adc_data = '0;
  logic [LANES*WORD_W-1:0] lane_data;
  logic [WORD_W-1:0] sync_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  readout_lane_mux #(.LANES(LANES), .WORD_W(WORD_W)) uut (
    .clk (clk), .rst (rst),
    .cfg_train_en (cfg_train_en), .cfg_bypass (cfg_bypass),
    .idle_a_i (idle_a), .idle_b_i (idle_b), .test_word_i (test_word),
    .kw_frame_start_i (kw_fs), .kw_line_start_i (kw_ls),
    .kw_line_end_i (kw_le), .kw_frame_end_i (kw_fe),
    .frame_valid_i (frame_valid), .line_valid_i (line_valid),
    .adc_valid_i (adc_valid), .adc_data_i (adc_data),
    .lane_data_o (lane_data), .sync_word_o (sync_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 normal, 1 test image, 2 training (R2)
  function automatic int mode_of(input logic tr, input logic bp);
    return bp ? (tr ? 2 : 1) : 0;
  endfunction

  task automatic chk(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, one register stage (R9)
  int   m_mode;
  logic m_tog, m_pfv, m_plv, m_first, e_valid;
  logic [WORD_W-1:0] e_lane [LANES];
  logic [WORD_W-1:0] e_sync;
  string e_ltag [LANES];
  string e_stag;
  logic [WORD_W-1:0] t_idle;
  logic t_slot;
  string t_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_tog <= 1'b0; m_mode <= 0; m_pfv <= 1'b0; m_plv <= 1'b0;
      m_first <= 1'b1; e_valid <= 1'b0;
    end else begin
      t_idle = m_tog ? idle_b : idle_a;
      t_slot = frame_valid && line_valid && adc_valid;
      for (int i = 0; i < LANES; i++) begin
        if (m_mode == 2) begin
          e_lane[i] <= t_idle; t_tag = "R3";
        end else if (t_slot) begin
          e_lane[i] <= (m_mode == 1) ? test_word : adc_data[i*WORD_W +: WORD_W];
          t_tag = (m_mode == 1) ? "R2,R4" : "R5,R9";
        end else begin
          e_lane[i] <= t_idle; t_tag = "R6";
        end
        if (frame_valid && m_mode != mode_of(cfg_train_en, cfg_bypass)) t_tag = "R8";
        if (m_first) t_tag = "R1";
        e_ltag[i] <= t_tag;
      end
      if (m_mode == 2) begin
        e_sync <= t_idle; e_stag <= "R3";
      end else begin
        e_stag <= "R7";
        if (frame_valid && !m_pfv)      e_sync <= kw_fs;
        else if (!frame_valid && m_pfv) e_sync <= kw_fe;
        else if (line_valid && !m_plv)  e_sync <= kw_ls;
        else if (!line_valid && m_plv)  e_sync <= kw_le;
        else                            e_sync <= t_idle;
      end
      m_tog <= ~m_tog; m_pfv <= frame_valid; m_plv <= line_valid;
      m_first <= 1'b0; e_valid <= 1'b1;
      if (!frame_valid) m_mode <= mode_of(cfg_train_en, cfg_bypass);
    end
  end

  always @(negedge clk) begin
    if (!rst && e_valid && !done) begin
      for (int i = 0; i < LANES; i++) chk(e_ltag[i], lane_data[i*WORD_W +: WORD_W], e_lane[i]);
      chk(e_stag, sync_word, e_sync);
    end
  end

  task automatic tick(input bit f, input bit l, input bit a);
    @(negedge clk);
    frame_valid = f; line_valid = l; adc_valid = a;
    for (int i = 0; i < LANES; i++) adc_data[i*WORD_W +: WORD_W] = WORD_W'($urandom);
    if ($urandom % 8 == 0) test_word = WORD_W'($urandom);
  endtask

  task automatic set_cfg(input int m);
    cfg_bypass   = (m != 0);
    cfg_train_en = (m == 2);
  endtask

  task automatic run_frame(input int nlines, input bit co_start, input bit co_end, input bit mid_change);
    repeat (2 + $urandom % 3) tick(0, 0, 0);
    if (!co_start) tick(1, 0, 0);
    for (int l = 0; l < nlines; l++) begin
      int len;
      len = 1 + $urandom % 6;
      repeat (len) tick(1, 1, bit'($urandom % 3 != 0));
      if (mid_change && l == 0) set_cfg($urandom % 3); // R8 mid-frame change
      if (l == nlines - 1 && co_end) tick(0, 0, 0);
      else tick(1, 0, 0);
    end
    if (!co_end) tick(0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle_a = 10'h2A5; idle_b = 10'h15A; test_word = 10'h3C3;
    kw_fs = 10'h201; kw_ls = 10'h102; kw_le = 10'h084; kw_fe = 10'h048;
    repeat (4) @(negedge clk);
    // R1: outputs zero in reset
    for (int i = 0; i < LANES; i++) chk("R1", lane_data[i*WORD_W +: WORD_W], '0);
    chk("R1", sync_word, '0);
    rst = 1'b0;
    // Directed: normal, coincident edges, then test, then mid-frame switches
    run_frame(2, 1'b1, 1'b1, 1'b0);
    set_cfg(1);
    run_frame(3, 1'b0, 1'b0, 1'b0);
    set_cfg(0);
    run_frame(2, 1'b1, 1'b0, 1'b0);
    set_cfg(1);
    run_frame(1, 1'b0, 1'b1, 1'b0);
    @(negedge clk); set_cfg(2);
    run_frame(2, 1'b1, 1'b1, 1'b0);
    set_cfg(0);
    run_frame(3, 1'b0, 1'b0, 1'b1);
    // Random frames
    for (int f = 0; f < 80; f++) begin
      if ($urandom % 4 == 0) begin idle_a = WORD_W'($urandom); idle_b = WORD_W'($urandom); end
      set_cfg($urandom % 4 == 0 ? 2 : $urandom % 2);
      run_frame(1 + $urandom % 4, bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));
    end
    repeat (3) tick(0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1'b1;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule